// File: doc/BRIEF.md
# Auto-Ranging Speed Capture Timer

This block times the interval between speed-capture events of a motor sensor. It uses a free-running count and a prescaler that picks its own range. The count advances once every 2^P count-clock ticks, where P is the current prescaler value. In tachogenerator or Hall mode the count clock is the system clock. In encoder mode it is the encoder pulse stream. The capture event depends on the sensor setup. In tachogenerator mode it is a tacho edge. In encoder manual mode it is a software read of the count's upper byte. In encoder automatic mode it is a periodic real-time tick.

The prescaler steps up when the count saturates, and the count is halved at that step so that its value stays consistent. The prescaler steps down when a capture records a count below a low threshold. Each capture copies the count and the prescaler into holding registers, and the live count then restarts from zero. Two sticky range flags record the up and down steps. A single mask gates them onto one interrupt line.

Control is a two-state machine. `ST_RUN` is the normal counting state. `ST_HOLD` is entered from `ST_RUN` when the count saturates while the prescaler is already at its top value. In `ST_HOLD` the count clock is gated off and the count holds at its maximum. Any capture returns the machine from `ST_HOLD` to `ST_RUN`. With no capture, each state stays where it is, except for the saturation transition just described.

Top module: `spdcap_top`

## Requirements
- R1: After reset the count, the prescaler, both holding registers, the capture strobe, both flags and the interrupt are all zero.
- R2: The count clock is chosen by `sensor_enc`. At 0 every system clock cycle is a tick. At 1 only cycles with `enc_pulse` high are ticks. The count increments on every 2^P-th tick after the last restart. With no tick the count does not change.
- R3: The capture source is chosen by the sensor setup. With `sensor_enc`=0 it is `tacho_evt`. With `sensor_enc`=1 and `enc_manual`=1 it is `hi_byte_rd`. With `sensor_enc`=1 and `enc_manual`=0 it is `rtc_tick`. The other two sources have no effect.
- R4: When an increment brings the count to all ones and P is below its maximum, P rises by one and the count becomes all ones shifted right by one bit. The up flag (`flag_up_o`, clear bit 0) is also set.
- R5: When a capture records a count below `LOW_THR` and P is above zero, P falls by one and the down flag (`flag_dn_o`, clear bit 1) is set.
- R6: At P = 0 a capture never lowers P and never sets the down flag.
- R7: When the count reaches all ones at maximum P, P stays unchanged and no flag is set. The count then holds at all ones until the next capture.
- R8: A capture taken while the count is frozen records all ones and the maximum P.
- R9: A capture copies the count and P into `cap_count_o` and `cap_psc_o`. `cap_strobe_o` pulses for one cycle, and the live count restarts at zero.
- R10: Each flag stays set until a 1 is written to its bit of `flag_clr`. A set event in the same cycle as a clear wins.
- R11: `irq_o` is high exactly when `range_irq_en` is high and at least one flag is set.
- R12: A count increment in the same cycle as a capture is applied before the copy. In this case the holding register gets the incremented or rescaled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor_enc | input | 1 | 0: tacho/Hall (system clock counts), 1: encoder (encoder pulses count) |
| enc_manual | input | 1 | Encoder capture mode: 1 capture on upper-byte read, 0 capture on real-time tick |
| tacho_evt | input | 1 | One-cycle pulse marking the active tacho edge |
| enc_pulse | input | 1 | One-cycle encoder count pulse |
| hi_byte_rd | input | 1 | One-cycle pulse marking a software read of the count's upper byte |
| rtc_tick | input | 1 | One-cycle periodic real-time tick |
| flag_clr | input | 2 | Write-1-to-clear strobes: bit 0 up flag, bit 1 down flag |
| range_irq_en | input | 1 | Range interrupt mask |
| count_o | output | CNT_W | Live count |
| psc_o | output | PSC_W | Current prescaler exponent |
| cap_count_o | output | CNT_W | Count held at the last capture |
| cap_psc_o | output | PSC_W | Prescaler held at the last capture |
| cap_strobe_o | output | 1 | One-cycle pulse after each capture |
| flag_up_o | output | 1 | Sticky prescaler-up flag |
| flag_dn_o | output | 1 | Sticky prescaler-down flag |
| irq_o | output | 1 | Masked range interrupt |

## Verification
The bench builds the block with a 6-bit count, a 2-bit prescaler and a threshold of 21. With these values a full climb from P = 0 to the frozen state at maximum P takes only a few hundred cycles. That brings every up step, the top-of-range freeze, each down step and the floor at zero into a short run. The bench sweeps capture intervals across all three source setups while the unused sources toggle. It checks every output on every cycle against an arithmetic model. It also checks count values derived by hand at the range boundaries.

// File: rtl/spdcap_pkg.sv
package spdcap_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } rng_state_t;

    typedef enum logic [1:0] {
        SRC_TACHO      = 2'd0,
        SRC_ENC_MANUAL = 2'd1,
        SRC_ENC_AUTO   = 2'd2
    } cap_src_t;

endpackage

// File: rtl/spdcap_src.sv
module spdcap_src
    import spdcap_pkg::*;
(
    input  logic sensor_enc,
    input  logic enc_manual,
    input  logic tacho_evt,
    input  logic enc_pulse,
    input  logic hi_byte_rd,
    input  logic rtc_tick,
    input  logic run,
    output logic cnt_tick,
    output logic capture
);

    cap_src_t src;

    always_comb begin
        if (!sensor_enc)     src = SRC_TACHO;
        else if (enc_manual) src = SRC_ENC_MANUAL;
        else                 src = SRC_ENC_AUTO;
    end

    always_comb begin
        unique case (src)
            SRC_TACHO: begin
                cnt_tick = run;
                capture  = tacho_evt;
            end
            SRC_ENC_MANUAL: begin
                cnt_tick = run & enc_pulse;
                capture  = hi_byte_rd;
            end
            SRC_ENC_AUTO: begin
                cnt_tick = run & enc_pulse;
                capture  = rtc_tick;
            end
            default: begin
                cnt_tick = 1'b0;
                capture  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spdcap_div.sv
module spdcap_div #(
    parameter int unsigned PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc,
    output logic             step
);

    localparam int unsigned DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = ~({DIV_W{1'b1}} << psc);
        step = tick && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (clr)  div_q <= '0;
        else if (tick) div_q <= div_q + 1'b1;
    end

    // R2: at prescaler zero every tick advances the count
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc == '0) |-> step);

    // R2: no tick, no step
    a_r2_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !step);

endmodule

// File: rtl/spdcap_range.sv
module spdcap_range
    import spdcap_pkg::*;
#(
    parameter int unsigned      CNT_W   = 16,
    parameter int unsigned      PSC_W   = 4,
    parameter logic [CNT_W-1:0] LOW_THR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             capture,
    output logic             run,
    output logic             div_clr,
    output logic             up,
    output logic             dn,
    output logic [CNT_W-1:0] cnt,
    output logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] cap_cnt,
    output logic [PSC_W-1:0] cap_psc,
    output logic             cap_strobe
);

    localparam logic [CNT_W-1:0] CMAX  = '1;
    localparam logic [CNT_W-1:0] CHALF = CMAX >> 1;
    localparam logic [PSC_W-1:0] PMAX  = '1;

    rng_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_adv;
    logic [PSC_W-1:0] psc_q, psc_d, psc_adv;
    logic [CNT_W-1:0] cap_cnt_q;
    logic [PSC_W-1:0] cap_psc_q;
    logic             strobe_q;
    logic             freeze;
    logic             low;

    // Count advance and saturation handling, applied before any capture
    always_comb begin
        cnt_adv = cnt_q;
        psc_adv = psc_q;
        up      = 1'b0;
        freeze  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (step) begin
                    if (cnt_q == CMAX - 1'b1) begin
                        if (psc_q != PMAX) begin
                            up      = 1'b1;
                            cnt_adv = CHALF;
                            psc_adv = psc_q + 1'b1;
                        end else begin
                            freeze  = 1'b1;
                            cnt_adv = CMAX;
                        end
                    end else begin
                        cnt_adv = cnt_q + 1'b1;
                    end
                end
                state_d = freeze ? ST_HOLD : ST_RUN;
            end
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_RUN;
        endcase

        low   = cnt_adv < LOW_THR;
        dn    = capture && low && (psc_adv != '0);
        cnt_d = capture ? '0 : cnt_adv;
        psc_d = dn ? psc_adv - 1'b1 : psc_adv;
        if (capture) state_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            psc_q     <= '0;
            cap_cnt_q <= '0;
            cap_psc_q <= '0;
            strobe_q  <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            psc_q    <= psc_d;
            strobe_q <= capture;
            if (capture) begin
                cap_cnt_q <= cnt_adv;
                cap_psc_q <= psc_adv;
            end
        end
    end

    always_comb begin
        run        = (state_q == ST_RUN);
        div_clr    = capture | up;
        cnt        = cnt_q;
        psc        = psc_q;
        cap_cnt    = cap_cnt_q;
        cap_psc    = cap_psc_q;
        cap_strobe = strobe_q;
    end

    // R4: saturation below the top prescaler halves the count
    a_r4_up_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !capture) |=> (cnt_q == CHALF) && (psc_q == $past(psc_q) + 1'b1));

    // R6: the prescaler never goes below zero on a capture
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && psc_q == '0 && !up) |=> (psc_q == '0));

    // R7: the frozen count keeps its maximum and the prescaler
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !capture) |=>
            (state_q == ST_HOLD) && (cnt_q == CMAX) && $stable(psc_q));

    // R7: no up step is raised while frozen
    a_r7_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !up);

    // R9: a capture restarts the count and strobes once
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (cnt_q == '0) && strobe_q);

endmodule

// File: rtl/spdcap_flags.sv
module spdcap_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_up,
    input  logic       set_dn,
    input  logic [1:0] clr,
    input  logic       irq_en,
    output logic       flag_up,
    output logic       flag_dn,
    output logic       irq
);

    logic up_q, dn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= set_up | (up_q & ~clr[0]);
            dn_q <= set_dn | (dn_q & ~clr[1]);
        end
    end

    always_comb begin
        flag_up = up_q;
        flag_dn = dn_q;
        irq     = irq_en & (up_q | dn_q);
    end

    // R10: flags are sticky until cleared
    a_r10_sticky_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !clr[0]) |=> up_q);
    a_r10_sticky_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_q && !clr[1]) |=> dn_q);

    // R10: a set event beats a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_up || set_dn) |=> (up_q || dn_q));

endmodule

// File: rtl/spdcap_top.sv
module spdcap_top #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PSC_W   = 4,
    parameter int unsigned LOW_THR = 'h5500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sensor_enc,
    input  logic             enc_manual,
    input  logic             tacho_evt,
    input  logic             enc_pulse,
    input  logic             hi_byte_rd,
    input  logic             rtc_tick,
    input  logic [1:0]       flag_clr,
    input  logic             range_irq_en,
    output logic [CNT_W-1:0] count_o,
    output logic [PSC_W-1:0] psc_o,
    output logic [CNT_W-1:0] cap_count_o,
    output logic [PSC_W-1:0] cap_psc_o,
    output logic             cap_strobe_o,
    output logic             flag_up_o,
    output logic             flag_dn_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] THR = LOW_THR[CNT_W-1:0];

    logic run, cnt_tick, capture, step, div_clr, up, dn;

    spdcap_src u_src (
        .sensor_enc (sensor_enc),
        .enc_manual (enc_manual),
        .tacho_evt  (tacho_evt),
        .enc_pulse  (enc_pulse),
        .hi_byte_rd (hi_byte_rd),
        .rtc_tick   (rtc_tick),
        .run        (run),
        .cnt_tick   (cnt_tick),
        .capture    (capture)
    );

    spdcap_div #(.PSC_W(PSC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cnt_tick),
        .clr   (div_clr),
        .psc   (psc_o),
        .step  (step)
    );

    spdcap_range #(.CNT_W(CNT_W), .PSC_W(PSC_W), .LOW_THR(THR)) u_range (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .capture    (capture),
        .run        (run),
        .div_clr    (div_clr),
        .up         (up),
        .dn         (dn),
        .cnt        (count_o),
        .psc        (psc_o),
        .cap_cnt    (cap_count_o),
        .cap_psc    (cap_psc_o),
        .cap_strobe (cap_strobe_o)
    );

    spdcap_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_up  (up),
        .set_dn  (dn),
        .clr     (flag_clr),
        .irq_en  (range_irq_en),
        .flag_up (flag_up_o),
        .flag_dn (flag_dn_o),
        .irq     (irq_o)
    );

endmodule

// File: tb/spdcap_top_tb.sv
module spdcap_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW   = 6;
    localparam int PW   = 2;
    localparam int THR  = 21;
    localparam int CMAX = (1 << CW) - 1;
    localparam int PMAX = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sensor_enc = 1'b0, enc_manual = 1'b0;
    logic          tacho_evt = 1'b0, enc_pulse = 1'b0, hi_byte_rd = 1'b0, rtc_tick = 1'b0;
    logic [1:0]    flag_clr = 2'b00;
    logic          range_irq_en = 1'b0;
    logic [CW-1:0] count_o, cap_count_o;
    logic [PW-1:0] psc_o, cap_psc_o;
    logic          cap_strobe_o, flag_up_o, flag_dn_o, irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    spdcap_top #(.CNT_W(CW), .PSC_W(PW), .LOW_THR(THR)) u_dut (
        .clk(clk), .rst_n(rst_n), .sensor_enc(sensor_enc), .enc_manual(enc_manual),
        .tacho_evt(tacho_evt), .enc_pulse(enc_pulse), .hi_byte_rd(hi_byte_rd),
        .rtc_tick(rtc_tick), .flag_clr(flag_clr), .range_irq_en(range_irq_en),
        .count_o(count_o), .psc_o(psc_o), .cap_count_o(cap_count_o),
        .cap_psc_o(cap_psc_o), .cap_strobe_o(cap_strobe_o), .flag_up_o(flag_up_o),
        .flag_dn_o(flag_dn_o), .irq_o(irq_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit noise_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // arithmetic model state
    int m_cnt = 0, m_psc = 0, m_div = 0, m_ccnt = 0, m_cpsc = 0;
    bit m_hold = 0, m_stb = 0, m_fu = 0, m_fd = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit tick, cap, step, up, fr, dn;
        int a, p, per;
        tick = m_hold ? 1'b0 : (sensor_enc ? enc_pulse : 1'b1);
        cap  = !sensor_enc ? tacho_evt : (enc_manual ? hi_byte_rd : rtc_tick);
        per  = 1 << m_psc;
        step = tick && ((m_div % per) == per - 1);
        a = m_cnt; p = m_psc; up = 0; fr = 0; dn = 0;
        if (step) begin
            if (a + 1 == CMAX) begin
                if (p < PMAX) begin up = 1; a = CMAX / 2; p = p + 1; end
                else begin fr = 1; a = CMAX; end
            end else a = a + 1;
        end
        if (tick) m_div = m_div + 1;
        if (cap) begin
            dn = (a < THR) && (p > 0);
            m_ccnt = a; m_cpsc = p;
            m_cnt = 0; m_psc = dn ? p - 1 : p;
            m_hold = 0; m_div = 0;
        end else begin
            m_cnt = a; m_psc = p;
            if (fr) m_hold = 1;
            if (up) m_div = 0;
        end
        m_stb = cap;
        m_fu = up | (m_fu & !flag_clr[0]);
        m_fd = dn | (m_fd & !flag_clr[1]);
    endtask

    task automatic compare();
        chk("R2 count", int'(count_o), m_cnt);
        chk("R4 prescaler", int'(psc_o), m_psc);
        chk("R9 held count", int'(cap_count_o), m_ccnt);
        chk("R9 held prescaler", int'(cap_psc_o), m_cpsc);
        chk("R9 strobe", int'(cap_strobe_o), int'(m_stb));
        chk("R10 up flag", int'(flag_up_o), int'(m_fu));
        chk("R10 down flag", int'(flag_dn_o), int'(m_fd));
        chk("R11 irq", int'(irq_o), int'(range_irq_en & (m_fu | m_fd)));
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (rst_n) model_step();
            @(negedge clk);
            compare();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (noise_on) begin
                // R3: inactive sources toggle freely
                if (!sensor_enc) begin
                    enc_pulse = lfsr[0]; hi_byte_rd = lfsr[1]; rtc_tick = lfsr[2];
                end else if (enc_manual) begin
                    enc_pulse = lfsr[3]; tacho_evt = lfsr[4]; rtc_tick = lfsr[5];
                end else begin
                    enc_pulse = lfsr[3]; tacho_evt = lfsr[4]; hi_byte_rd = lfsr[6];
                end
            end
        end
    endtask

    task automatic cap_pulse();
        if (!sensor_enc)     tacho_evt = 1'b1;
        else if (enc_manual) hi_byte_rd = 1'b1;
        else                 rtc_tick = 1'b1;
        cyc(1);
        if (!sensor_enc)     tacho_evt = 1'b0;
        else if (enc_manual) hi_byte_rd = 1'b0;
        else                 rtc_tick = 1'b0;
    endtask

    task automatic clear_flags(logic [1:0] v);
        flag_clr = v;
        cyc(1);
        flag_clr = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 prescaler", int'(psc_o), 0);
        chk("R1 held count", int'(cap_count_o), 0);
        chk("R1 flags", int'({flag_up_o, flag_dn_o, irq_o, cap_strobe_o}), 0);
        rst_n = 1'b1;
        noise_on = 1'b1;

        // R12 and R9: at prescaler 0 a capture after k idle cycles holds k+1
        for (int k = 0; k <= 30; k++) begin
            cyc(k);
            cap_pulse();
            chk("R12 same-cycle count", int'(cap_count_o), k + 1);
            chk("R6 prescaler stays 0", int'(psc_o), 0);
            chk("R9 restart", int'(count_o), 0);
        end

        // R4: 63 ticks at prescaler 0 reach the top and halve
        cyc(63);
        chk("R4 halved count", int'(count_o), CMAX / 2);
        chk("R4 prescaler up", int'(psc_o), 1);
        chk("R4 up flag", int'(flag_up_o), 1);
        range_irq_en = 1'b0;
        cyc(1);
        chk("R11 masked", int'(irq_o), 0);
        range_irq_en = 1'b1;
        cyc(1);
        chk("R11 unmasked", int'(irq_o), 1);
        clear_flags(2'b01);
        chk("R10 cleared", int'(flag_up_o), 0);

        // R7: climb to the top prescaler and freeze
        cyc(1500);
        chk("R7 frozen count", int'(count_o), CMAX);
        chk("R7 top prescaler", int'(psc_o), PMAX);
        clear_flags(2'b11);
        cyc(40);
        chk("R7 no flag at top", int'(flag_up_o), 0);
        chk("R7 still frozen", int'(count_o), CMAX);

        // R8: capture while frozen
        cap_pulse();
        chk("R8 held max", int'(cap_count_o), CMAX);
        chk("R8 held prescaler", int'(cap_psc_o), PMAX);

        // R5 and R6: immediate captures walk the prescaler down to 0
        for (int p = PMAX; p > 0; p--) begin
            cap_pulse();
            chk("R5 step down", int'(psc_o), p - 1);
            chk("R5 down flag", int'(flag_dn_o), 1);
        end
        clear_flags(2'b10);
        cap_pulse();
        chk("R6 floor", int'(psc_o), 0);
        chk("R6 no down flag", int'(flag_dn_o), 0);

        // sweep of capture intervals in all source setups
        for (int mode = 0; mode < 3; mode++) begin
            sensor_enc = (mode != 0);
            enc_manual = (mode == 1);
            tacho_evt = 0; hi_byte_rd = 0; rtc_tick = 0;
            for (int n = 1; n <= 120; n += 3) begin
                range_irq_en = n[2];
                if (n % 7 == 0) flag_clr = 2'b11;
                cyc(1);
                flag_clr = 2'b00;
                cyc(n);
                cap_pulse();
            end
        end

        // R2: encoder mode without pulses leaves the count still
        sensor_enc = 1'b1; enc_manual = 1'b1;
        noise_on = 1'b0; enc_pulse = 1'b0; tacho_evt = 1'b0; rtc_tick = 1'b0;
        cap_pulse();
        cyc(12);
        chk("R2 no encoder pulse", int'(count_o), 0);
        // R3: tacho and tick ignored in manual encoder mode
        tacho_evt = 1'b1; rtc_tick = 1'b1;
        cyc(3);
        tacho_evt = 1'b0; rtc_tick = 1'b0;
        cyc(1);
        chk("R3 ignored sources", int'(cap_strobe_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule